// File: doc/BRIEF.md
# Word/Byte Parallel Host Port for a Sampling Converter

This block is the host-facing side of a 12-bit sampling converter. A processor writes a 12-bit control word into it and reads the latest conversion result back over one data bus. The bus width is chosen at run time by a mode input. In word mode every transfer carries all 12 bits. In byte mode transfers use the bottom eight bus lines, and bus line 8 turns into a half-select input. In byte mode a control word takes two writes, low half first. A read of the upper half returns the top four result bits together with the 3-bit tag of the channel that produced the result.

The block also times conversions. A falling edge on the active-low start input begins a conversion and raises busy. After a fixed, parameterised number of clock cycles, busy drops and the supplied result and channel tag are captured into the read-back registers. A host can treat the falling busy edge as its interrupt. The chip-select, read and write strobes are active low and combined inside the block, so chip select and read may be tied together. Pad drivers and analog circuitry lie outside the block. The read bus is delivered as a data value plus an enable for an external driver.

Top module: `adc_host_port`

## Requirements
- R1: After reset, `busy` is 0, `ctrlReg` is 0, and a read returns 0 in every mode.
- R2: In word mode (`wordMode`=1), the first clock edge that sees `csN` and `wrN` both low loads all 12 bits of `dataIn` into `ctrlReg`.
- R3: In byte mode (`wordMode`=0), a write with `dataIn[8]`=0 stores `dataIn[7:0]` as the pending low half and leaves `ctrlReg` unchanged. A following write with `dataIn[8]`=1 loads `ctrlReg` with `dataIn[3:0]` in bits 11:8 and the pending half in bits 7:0.
- R4: In word mode, while `csN` and `rdN` are both low, `dataOut` equals the 12-bit result and `dataOutEn` is 1.
- R5: In a byte-mode read with `dataIn[8]`=0, `dataOut[7:0]` is result bits 7:0 and `dataOut[11:8]` is 0.
- R6: In a byte-mode read with `dataIn[8]`=1, `dataOut[3:0]` is result bits 11:8 and `dataOut[6:4]` is the channel tag. `dataOut[11:7]` is 0.
- R7: When `csN` or `rdN` is high, `dataOut` is 0 and `dataOutEn` is 0.
- R8: A falling edge on `convStartN` seen at a clock edge while idle sets `busy` at that edge. `busy` then stays high for exactly `CONV_CYCLES` cycles.
- R9: At the edge where `busy` falls, the result register takes `resultIn`. The tag register takes the value that `chanIn` had at the start edge.
- R10: A falling edge on `convStartN` while `busy` is high is ignored and does not lengthen the conversion.
- R11: The result and tag hold until the next conversion completes. Repeated reads return the same data even if `resultIn` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| wordMode | input | 1 | 1 selects 12-bit word transfers, 0 selects byte transfers |
| dataIn | input | 12 | Incoming bus lines; bit 8 is the half-select in byte mode |
| convStartN | input | 1 | Conversion start; a falling edge begins a conversion |
| resultIn | input | 12 | Converter result captured when a conversion ends |
| chanIn | input | 3 | Channel tag sampled at the start edge |
| dataOut | output | 12 | Read data for the pad drivers |
| dataOutEn | output | 1 | Drive enable for the read bus |
| busy | output | 1 | High while a conversion is in progress |
| ctrlReg | output | 12 | Current control word |

## Verification
A table of results and channel tags is pushed through full conversions. Each entry is read in word mode and as both byte halves. All-zero and all-one results show that the zero fill around the tag is in place. Asymmetric patterns such as 0xABC and 0x5A3 expose swapped halves or a misplaced tag field.

Directed tests cover the following cases:
- Word writes and split byte writes, which separate a low-half write that leaks into the register from a correct two-step load.
- A tag that changes during the conversion, which shows whether the tag is sampled at the start edge or at the end.
- A second start edge during busy, where any added busy cycle is a failure.
- A result input that changes without a new conversion, which shows whether the register holds.

// File: rtl/adc_host_port_pkg.sv
package adc_host_port_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadWord;    // full-width control write
    logic loadLow;     // byte mode, low half write
    logic loadHigh;    // byte mode, high half write (commits)
    logic startConv;   // accepted start edge
    logic finishConv;  // last busy cycle, capture result
    logic rdEn;        // read strobe active
    logic rdHigh;      // byte mode upper half selected
    logic byteMode;    // byte transfers selected
  } hostStrobe_t;

endpackage

// File: rtl/adc_host_port_ctrl.sv
module adc_host_port_ctrl
  import adc_host_port_pkg::*;
#(
  parameter int CONV_CYCLES = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        wordMode,
  input  logic        halfSel,
  input  logic        convStartN,
  output hostStrobe_t strb,
  output logic        busy
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             wrAct;
  logic             wrActD;
  logic             wrPulse;
  logic             convD;
  logic             startFall;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             lastCycle;

  // Write strobe: only the first edge of an active pulse counts
  assign wrAct   = !csN && !wrN;
  assign wrPulse = wrAct && !wrActD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrActD <= 1'b0;
    else       wrActD <= wrAct;
  end

  // Start edge detection on the sampled start input
  assign startFall = convD && !convStartN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convD <= 1'b1;
    else       convD <= convStartN;
  end

  assign lastCycle = busyQ && (cntQ == '0);

  // Conversion timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (!busyQ) begin
      if (startFall) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_LOAD;
      end
    end else if (lastCycle) begin
      busyQ <= 1'b0;
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadWord   = wrPulse && wordMode;
    strb.loadLow    = wrPulse && !wordMode && !halfSel;
    strb.loadHigh   = wrPulse && !wordMode && halfSel;
    strb.startConv  = startFall && !busyQ;
    strb.finishConv = lastCycle;
    strb.rdEn       = !csN && !rdN;
    strb.rdHigh     = halfSel;
    strb.byteMode   = !wordMode;
  end

  assign busy = busyQ;

endmodule

// File: rtl/adc_host_port_dp.sv
module adc_host_port_dp
  import adc_host_port_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] resultIn,
  input  logic [CHAN_W-1:0] chanIn,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] lowPend;
  logic [DATA_W-1:0] ctrlQ;
  logic [CHAN_W-1:0] chanPend;
  logic [DATA_W-1:0] resQ;
  logic [CHAN_W-1:0] chanQ;
  logic [DATA_W-1:0] lowLane;
  logic [DATA_W-1:0] hiLane;

  // Control register, word load or two-step byte load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPend <= '0;
      ctrlQ   <= '0;
    end else begin
      if (strb.loadWord) ctrlQ   <= dataIn;
      if (strb.loadLow)  lowPend <= dataIn[BYTE_W-1:0];
      if (strb.loadHigh) ctrlQ   <= {dataIn[HI_W-1:0], lowPend};
    end
  end

  // Result and channel tag capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanPend <= '0;
      resQ     <= '0;
      chanQ    <= '0;
    end else begin
      if (strb.startConv) chanPend <= chanIn;
      if (strb.finishConv) begin
        resQ  <= resultIn;
        chanQ <= chanPend;
      end
    end
  end

  // Byte lanes, built bit by bit with zero fill
  for (genvar i = 0; i < DATA_W; i++) begin : gLane
    if (i < BYTE_W) begin : gLow
      assign lowLane[i] = resQ[i];
    end else begin : gLowZ
      assign lowLane[i] = 1'b0;
    end
    if (i < HI_W) begin : gHiRes
      assign hiLane[i] = resQ[BYTE_W + i];
    end else if (i < HI_W + CHAN_W) begin : gHiTag
      assign hiLane[i] = chanQ[i - HI_W];
    end else begin : gHiZ
      assign hiLane[i] = 1'b0;
    end
  end

  always_comb begin
    dataOut = '0;
    if (strb.rdEn) begin
      if (!strb.byteMode)   dataOut = resQ;
      else if (strb.rdHigh) dataOut = hiLane;
      else                  dataOut = lowLane;
    end
  end

  assign dataOutEn = strb.rdEn;
  assign ctrlReg   = ctrlQ;

endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_host_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CHAN_W      = 3,
  parameter int CONV_CYCLES = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              convStartN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic [CHAN_W-1:0] chanIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busy,
  output logic [DATA_W-1:0] ctrlReg
);

  hostStrobe_t strb;

  adc_host_port_ctrl #(
    .CONV_CYCLES(CONV_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .wrN       (wrN),
    .wordMode  (wordMode),
    .halfSel   (dataIn[BYTE_W]),
    .convStartN(convStartN),
    .strb      (strb),
    .busy      (busy)
  );

  adc_host_port_dp #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W),
    .CHAN_W(CHAN_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .resultIn (resultIn),
    .chanIn   (chanIn),
    .ctrlReg  (ctrlReg),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );

endmodule

// File: rtl/adc_host_port_chk.sv
module adc_host_port_chk #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic              wordMode,
  input logic              halfSel,
  input logic              convStartN,
  input logic              busy,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic [DATA_W-1:0] ctrlReg
);

  logic        rdAct;
  logic        wrAct;
  logic [15:0] busyLen;

  assign rdAct = !csN && !rdN;
  assign wrAct = !csN && !wrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(convStartN) && !convStartN) |=> busy); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 16'(CONV_CYCLES))); // R10

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !rdAct |-> (dataOut == '0 && !dataOutEn)); // R7

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && !wordMode) |-> (dataOut[DATA_W-1:BYTE_W] == '0 &&
                              (!halfSel || !dataOut[BYTE_W-1]))); // R6

  AST_LOW_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && !$past(wrAct) && !wordMode && !halfSel) |=> $stable(ctrlReg)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && wordMode && $past(rdAct && wordMode) && !$fell(busy))
      |-> $stable(dataOut)); // R11

endmodule

bind adc_host_port adc_host_port_chk #(
  .DATA_W(DATA_W),
  .BYTE_W(BYTE_W),
  .CONV_CYCLES(CONV_CYCLES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .rdN       (rdN),
  .wrN       (wrN),
  .wordMode  (wordMode),
  .halfSel   (dataIn[BYTE_W]),
  .convStartN(convStartN),
  .busy      (busy),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn),
  .ctrlReg   (ctrlReg)
);

// File: tb/tb_adc_host_port.sv
module tb_adc_host_port;

  localparam int CONV = 14;
  localparam int NVEC = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic        wordMode = 1'b1;
  logic [11:0] dataIn = '0;
  logic        convStartN = 1'b1;
  logic [11:0] resultIn = '0;
  logic [2:0]  chanIn = '0;
  logic [11:0] dataOut;
  logic        dataOutEn;
  logic        busy;
  logic [11:0] ctrlReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  adc_host_port #(.CONV_CYCLES(CONV)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .wordMode(wordMode), .dataIn(dataIn), .convStartN(convStartN),
    .resultIn(resultIn), .chanIn(chanIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .busy(busy), .ctrlReg(ctrlReg)
  );

  // {result, tag, word read, low read, high read}
  localparam logic [50:0] VEC [NVEC] = '{
    {12'hABC, 3'd5, 12'hABC, 12'h0BC, 12'h05A},
    {12'h000, 3'd0, 12'h000, 12'h000, 12'h000},
    {12'hFFF, 3'd7, 12'hFFF, 12'h0FF, 12'h07F},
    {12'h5A3, 3'd2, 12'h5A3, 12'h0A3, 12'h025},
    {12'h801, 3'd3, 12'h801, 12'h001, 12'h038}
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic wm, input logic [11:0] d);
    @(negedge clk);
    wordMode = wm; dataIn = d; csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic doRead(input logic wm, input logic hb, output logic [11:0] v, output logic en);
    @(negedge clk);
    wordMode = wm; dataIn = {3'b0, hb, 8'h00}; csN = 1'b0; rdN = 1'b0;
    #1;
    v = dataOut; en = dataOutEn;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic runConv(input logic [11:0] res, input logic [2:0] ch,
                         input bit glitch, output int len);
    @(negedge clk);
    resultIn = res; chanIn = ch; convStartN = 1'b0;
    @(negedge clk);
    convStartN = 1'b1; chanIn = ~ch;
    len = 0;
    while (busy) begin
      len++;
      if (glitch && len == 3) convStartN = 1'b0;
      if (glitch && len == 5) convStartN = 1'b1;
      @(negedge clk);
    end
    convStartN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    logic        en;
    int          len;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {11'b0, busy}, 12'h000);
    check("R1 ctrl", ctrlReg, 12'h000);
    rstN = 1'b1;
    doRead(1'b1, 1'b0, v, en);
    check("R1 read", v, 12'h000);

    // Table walk: R8 R9 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      runConv(VEC[i][50:39], VEC[i][38:36], 1'b0, len);
      check("R8 busy length", 12'(len), 12'(CONV));
      doRead(1'b1, 1'b0, v, en);
      check("R4 word read", v, VEC[i][35:24]);
      check("R4 enable", {11'b0, en}, 12'h001);
      doRead(1'b0, 1'b0, v, en);
      check("R5 low read", v, VEC[i][23:12]);
      doRead(1'b0, 1'b1, v, en); // R9 tag sampled at start, R6 placement
      check("R6 high read", v, VEC[i][11:0]);
    end

    // R2: word write
    doWrite(1'b1, 12'h9C6);
    check("R2 word write", ctrlReg, 12'h9C6);

    // R3: byte writes
    doWrite(1'b0, 12'h05B);
    check("R3 low half holds", ctrlReg, 12'h9C6);
    doWrite(1'b0, 12'h103);
    check("R3 high half commit", ctrlReg, 12'h35B);

    // R7: partial strobes
    @(negedge clk);
    wordMode = 1'b1; csN = 1'b0; rdN = 1'b1; #1;
    check("R7 cs only", dataOut, 12'h000);
    check("R7 cs only en", {11'b0, dataOutEn}, 12'h000);
    csN = 1'b1; rdN = 1'b0; #1;
    check("R7 rd only", dataOut, 12'h000);
    rdN = 1'b1;

    // R10: start edge during busy ignored
    runConv(12'h3C5, 3'd6, 1'b1, len);
    check("R10 busy not extended", 12'(len), 12'(CONV));
    doRead(1'b1, 1'b0, v, en);
    check("R10 result", v, 12'h3C5);

    // R11: result holds while input changes
    resultIn = 12'h111;
    repeat (4) @(negedge clk);
    doRead(1'b1, 1'b0, v, en);
    check("R11 hold first", v, 12'h3C5);
    doRead(1'b1, 1'b0, v, en);
    check("R11 hold second", v, 12'h3C5);
    doRead(1'b0, 1'b1, v, en);
    check("R11 tag hold", v, 12'h063);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule